// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a 32-bit down-counter behind a small word-addressed register bank. Software loads an interval as two 16-bit halves, starts and stops the count with self-clearing command bits, and picks one-shot or auto-reload operation. When the count expires, a sticky timeout flag is raised. A level interrupt follows that flag whenever the interrupt enable is set.

The bus is a plain synchronous port with a byte address, a write strobe with 16-bit data, and a read strobe with combinational read data. The block's clock is also the count tick, so one interval of value P lasts P+1 clock cycles. Software reads the live count by writing to either snapshot register and then reading back the two captured halves.

Top module: `interval_timer`

## Requirements
- R1: The word offset is the byte address shifted right by 2, and the two low address bits are ignored. Offset 0 is status, 1 is control, 2 is period low, 3 is period high, 4 is snapshot low and 5 is snapshot high. A read of offset 6 or 7 returns 0, a write to offset 6 or 7 changes nothing, and the read data is 0 whenever the read strobe is low.
- R2: A control write stores data bit 0 as the interrupt enable and data bit 1 as the continuous-mode select. A control read returns only those two bits in positions 1:0.
- R3: A control write with bit 3 set leaves the timer stopped, even when bit 2 is also set. A control write with bit 2 set and bit 3 clear leaves it running. While stopped, the count holds, and a later start resumes from the held value.
- R4: While the timer is running, the count decreases by one on every clock. When the count is 0, the next clock reloads the period and sets the timeout flag, so an interval of period P lasts P+1 clocks.
- R5: In one-shot mode (control bit 1 clear), a timeout clears the running flag and the count then holds at the period value. In continuous mode, counting carries on from the reloaded value.
- R6: A write to period low or period high stores the 16 data bits in that half. The same write stops the timer and loads both the count and the reload value with the new {high, low}.
- R7: A write to either snapshot offset captures the count as it stood before that clock. The low 16 bits go to snapshot low and the upper 16 bits go to snapshot high.
- R8: Status reads return the timeout flag in bit 0 and the running flag in bit 1. Any write to status clears the timeout flag, whatever the data, unless a timeout happens in the same cycle; in that case the flag stays set.
- R9: The interrupt output equals timeout flag AND interrupt enable, with no added cycle of delay.
- R10: After reset every register reads 0, the timer is stopped, and both the count and the reload value are 0xFFFFFFFF until the first period write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock and count tick |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | HALF_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | HALF_W | Read data, combinational, 0 when not reading |
| irq | output | 1 | Level interrupt |

## Verification
A software write to status and a hardware timeout can land in the same cycle, and so can a control write and a one-shot expiry. A status write and a timeout compete to clear and to set the timeout flag. A stop or start command competes with a one-shot expiry to decide the running flag. The bench uses a short continuous period and issues the status write exactly in the cycle its model predicts the count is at zero. It then expects the timeout flag to read back set. Random traffic with tiny periods produces further collisions of period writes, snapshots and commands with expiry, and the bench judges each of them against its cycle model at the next read.

// File: rtl/tmr_pkg.sv
// Package: shared register offsets, bit positions and write-strobe indices
// for the interval timer. Assumes a register bank of six words.
package tmr_pkg;
    localparam int NUM_REGS = 6;

    // Word offsets; the snapshot pair order matters to the read mux.
    localparam int OFF_STAT = 0;
    localparam int OFF_CTRL = 1;
    localparam int OFF_PLO  = 2;
    localparam int OFF_PHI  = 3;
    localparam int OFF_SLO  = 4;
    localparam int OFF_SHI  = 5;

    // Control bits.
    localparam int CB_IEN  = 0;
    localparam int CB_CONT = 1;
    localparam int CB_GO   = 2;
    localparam int CB_HALT = 3;

    // Status bits.
    localparam int SB_TO  = 0;
    localparam int SB_RUN = 1;
endpackage

// File: rtl/tmr_decode.sv
// Module: address decoder. Turns a word offset and a write strobe into one
// write-select line per register. Assumes the offset is already shifted.
module tmr_decode #(
    parameter int OFF_W = 3,
    parameter int NREG  = 6
) (
    input  logic [OFF_W-1:0] off,
    input  logic             we,
    output logic [NREG-1:0]  wsel
);
    // One compare per register.
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign wsel[i] = we && (off == OFF_W'(i));
    end
endmodule

// File: rtl/tmr_counter.sv
// Module: the down-counter and its reload register. It loads on a period
// write, otherwise decrements while enabled and reloads after zero.
// Assumes the enable comes from the running flag held by the register bank.
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;

    // Expiry: running and about to pass below zero.
    assign timeout = run && (cnt_q == '0);
    assign cnt     = cnt_q;

    // Count, reload and period-load sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= ALL_ONES;
            reload_q <= ALL_ONES;
        end else if (load) begin
            cnt_q    <= load_val;
            reload_q <= load_val;
        end else if (run) begin
            cnt_q <= timeout ? reload_q : cnt_q - 1'b1;
        end
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q)); // R3
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !load) |=> (cnt_q == $past(reload_q))); // R5
endmodule

// File: rtl/tmr_regs.sv
// Module: software-visible state: control bits, status flags, period halves
// and snapshot halves, plus the running-flag priority logic. Assumes
// one-hot write selects from the decoder and the expiry pulse from the counter.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int NREG   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREG-1:0]     wsel,
    input  logic [HALF_W-1:0]   wdata,
    input  logic                timeout,
    input  logic [2*HALF_W-1:0] cnt,
    output logic                ien,
    output logic                cont,
    output logic                tflag,
    output logic                running,
    output logic [HALF_W-1:0]   per_lo,
    output logic [HALF_W-1:0]   per_hi,
    output logic [HALF_W-1:0]   snap_lo,
    output logic [HALF_W-1:0]   snap_hi,
    output logic                load,
    output logic [2*HALF_W-1:0] load_val
);
    localparam int CNT_W = 2 * HALF_W;

    logic wr_stat, wr_ctrl, wr_lo, wr_hi, wr_snap;
    logic tflag_nx, run_nx;

    assign wr_stat = wsel[OFF_STAT];
    assign wr_ctrl = wsel[OFF_CTRL];
    assign wr_lo   = wsel[OFF_PLO];
    assign wr_hi   = wsel[OFF_PHI];
    assign wr_snap = wsel[OFF_SLO] | wsel[OFF_SHI];

    // Period load value merges the half being written with the stored one.
    assign load     = wr_lo | wr_hi;
    assign load_val = {wr_hi ? wdata : per_hi, wr_lo ? wdata : per_lo};

    // Timeout flag: a new expiry beats a clearing write.
    always_comb begin
        if (timeout)      tflag_nx = 1'b1;
        else if (wr_stat) tflag_nx = 1'b0;
        else              tflag_nx = tflag;
    end

    // Running flag priority: period write, stop, one-shot expiry, start.
    always_comb begin
        if (load)                          run_nx = 1'b0;
        else if (wr_ctrl && wdata[CB_HALT]) run_nx = 1'b0;
        else if (timeout && !cont)          run_nx = 1'b0;
        else if (wr_ctrl && wdata[CB_GO])   run_nx = 1'b1;
        else                                run_nx = running;
    end

    // Register updates on bus writes and flag updates every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien     <= 1'b0;
            cont    <= 1'b0;
            tflag   <= 1'b0;
            running <= 1'b0;
            per_lo  <= '0;
            per_hi  <= '0;
            snap_lo <= '0;
            snap_hi <= '0;
        end else begin
            if (wr_ctrl) begin
                ien  <= wdata[CB_IEN];
                cont <= wdata[CB_CONT];
            end
            if (wr_lo) per_lo <= wdata;
            if (wr_hi) per_hi <= wdata;
            if (wr_snap) begin
                snap_lo <= cnt[HALF_W-1:0];
                snap_hi <= cnt[CNT_W-1:HALF_W];
            end
            tflag   <= tflag_nx;
            running <= run_nx;
        end
    end

    AST_TIMEOUT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> tflag); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !timeout) |=> !tflag); // R8
    AST_PERIOD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !running); // R6
    AST_HALT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CB_HALT]) |=> !running); // R3
    AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !cont) |=> !running); // R5
    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_snap |=> ({snap_hi, snap_lo} == $past(cnt))); // R7
endmodule

// File: rtl/interval_timer.sv
// Module: top of the interval timer. Decodes the byte address, hosts the
// register bank and counter, muxes read data and forms the interrupt.
// Assumes single-cycle bus accesses; byte address bits 1:0 are ignored.
module interval_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [HALF_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int OFF_W = ADDR_W - 2;
    localparam int CNT_W = 2 * HALF_W;

    logic [OFF_W-1:0]    off;
    logic                addr_byte_unused;
    logic [NUM_REGS-1:0] wsel;
    logic                ien, cont, tflag, running;
    logic [HALF_W-1:0]   per_lo, per_hi, snap_lo, snap_hi;
    logic                load, timeout;
    logic [CNT_W-1:0]    load_val, cnt;
    logic [HALF_W-1:0]   rd_mux;

    assign off              = bus_addr[ADDR_W-1:2];
    assign addr_byte_unused = ^bus_addr[1:0];

    tmr_decode #(.OFF_W(OFF_W), .NREG(NUM_REGS)) u_dec (
        .off  (off),
        .we   (bus_we),
        .wsel (wsel)
    );

    tmr_regs #(.HALF_W(HALF_W), .NREG(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wsel     (wsel),
        .wdata    (bus_wdata),
        .timeout  (timeout),
        .cnt      (cnt),
        .ien      (ien),
        .cont     (cont),
        .tflag    (tflag),
        .running  (running),
        .per_lo   (per_lo),
        .per_hi   (per_hi),
        .snap_lo  (snap_lo),
        .snap_hi  (snap_hi),
        .load     (load),
        .load_val (load_val)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .load     (load),
        .load_val (load_val),
        .cnt      (cnt),
        .timeout  (timeout)
    );

    // Read multiplexer over the six registers; unused offsets read zero.
    always_comb begin
        rd_mux = '0;
        case (int'(off))
            OFF_STAT: begin
                rd_mux[SB_TO]  = tflag;
                rd_mux[SB_RUN] = running;
            end
            OFF_CTRL: begin
                rd_mux[CB_IEN]  = ien;
                rd_mux[CB_CONT] = cont;
            end
            OFF_PLO: rd_mux = per_lo;
            OFF_PHI: rd_mux = per_hi;
            OFF_SLO: rd_mux = snap_lo;
            OFF_SHI: rd_mux = snap_hi;
            default: rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_re ? rd_mux : '0;
    assign irq       = tflag & ien;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(off) == OFF_STAT && !timeout) |=> !irq); // R9
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0)); // R1
endmodule

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
    localparam real CLK_HALF = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state kept by the bench.
    logic        m_tf, m_run, m_ien, m_cont;
    logic [15:0] m_plo, m_phi, m_slo, m_shi;
    logic [31:0] m_cnt, m_rel;

    always #(CLK_HALF) clk = ~clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_read(input int off);
        case (off)
            0: return {14'd0, m_run, m_tf};
            1: return {14'd0, m_cont, m_ien};
            2: return m_plo;
            3: return m_phi;
            4: return m_slo;
            5: return m_shi;
            default: return 16'd0;
        endcase
    endfunction

    function automatic string tag_of(input int off);
        case (off)
            0: return "R8";
            1: return "R2";
            2, 3: return "R6";
            4, 5: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic model_reset();
        m_tf = 0; m_run = 0; m_ien = 0; m_cont = 0;
        m_plo = 0; m_phi = 0; m_slo = 0; m_shi = 0;
        m_cnt = 32'hFFFF_FFFF; m_rel = 32'hFFFF_FFFF;
    endtask

    // Advance the reference by one clock edge.
    task automatic model_step(input bit we, input int off, input logic [15:0] d);
        bit          to, ld, ctl;
        logic [15:0] nlo, nhi;
        logic [31:0] old_cnt;
        to = m_run && (m_cnt == 0);
        ld = we && (off == 2 || off == 3);
        ctl = we && off == 1;
        nlo = (we && off == 2) ? d : m_plo;
        nhi = (we && off == 3) ? d : m_phi;
        old_cnt = m_cnt;
        if (ld) begin
            m_cnt = {nhi, nlo}; m_rel = {nhi, nlo};
        end else if (m_run) begin
            m_cnt = to ? m_rel : m_cnt - 1;
        end
        if (ld)                 m_run = 0;
        else if (ctl && d[3])   m_run = 0;
        else if (to && !m_cont) m_run = 0;
        else if (ctl && d[2])   m_run = 1;
        if (to) m_tf = 1;
        else if (we && off == 0) m_tf = 0;
        if (ctl) begin m_ien = d[0]; m_cont = d[1]; end
        m_plo = nlo; m_phi = nhi;
        if (we && (off == 4 || off == 5)) begin
            m_slo = old_cnt[15:0]; m_shi = old_cnt[31:16];
        end
    endtask

    // One bus cycle: drive at the falling edge, check, then step the model.
    task automatic cyc(input bit we, input bit re, input int off,
                       input logic [15:0] d, input string tag);
        @(negedge clk);
        bus_we = we; bus_re = re; bus_wdata = d;
        bus_addr = {off[2:0], 2'($urandom)};
        #1;
        check(irq === (m_tf & m_ien), "R9", {31'd0, irq}, {31'd0, m_tf & m_ien});
        if (re)
            check(bus_rdata === exp_read(off), tag, {16'd0, bus_rdata}, {16'd0, exp_read(off)});
        else
            check(bus_rdata === 16'd0, "R1", {16'd0, bus_rdata}, 32'd0);
        model_step(we, off, d);
    endtask

    task automatic wr(input int off, input logic [15:0] d, input string tag);
        cyc(1'b1, 1'b0, off, d, tag);
    endtask

    task automatic rd(input int off, input string tag);
        cyc(1'b0, 1'b1, off, 16'd0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 16'd0, "R4");
    endtask

    initial begin
        #(8.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: reset contents and the all-ones count.
        for (int o = 0; o < 8; o++) rd(o, "R10");
        wr(4, 16'h0, "R7");
        rd(4, "R10"); check(bus_rdata === 16'hFFFF, "R10 snap lo", bus_rdata, 32'hFFFF);
        rd(5, "R10"); check(bus_rdata === 16'hFFFF, "R10 snap hi", bus_rdata, 32'hFFFF);
        wr(1, 16'h4, "R3"); idle(5); wr(5, 16'h0, "R7"); rd(4, "R7"); rd(5, "R7");

        // R6 / R5: period 3, one-shot with interrupt.
        wr(2, 16'h0003, "R6"); wr(3, 16'h0000, "R6"); rd(0, "R6");
        wr(1, 16'h0005, "R3");
        idle(4);
        rd(0, "R5"); check(bus_rdata === 16'h0001, "R5 one-shot status", bus_rdata, 32'h1);
        check(irq === 1'b1, "R9 irq after P+1", {31'd0, irq}, 32'd1);
        wr(4, 16'h0, "R7"); rd(4, "R5");
        check(bus_rdata === 16'h0003, "R5 hold at period", bus_rdata, 32'h3);
        wr(0, 16'hFFFF, "R8"); rd(0, "R8");

        // R2: only bits 1:0 read back.
        wr(1, 16'hFFF3 & ~16'h000C, "R2"); rd(1, "R2");
        check(bus_rdata === 16'h0003, "R2 ctrl readback", bus_rdata, 32'h3);

        // R5 continuous, R8 clear colliding with timeout.
        wr(2, 16'h0002, "R6"); wr(1, 16'h0007, "R3");
        for (int k = 0; k < 40; k++) begin
            if (m_run && m_cnt == 0) begin
                wr(0, 16'h0, "R8"); rd(0, "R8");
                check(bus_rdata[0] === 1'b1, "R8 timeout wins", bus_rdata, 32'h1);
            end else rd(0, "R5");
        end
        // R6: period write while running halts.
        wr(3, 16'h0001, "R6"); rd(0, "R6"); rd(3, "R6");
        // R3: start and stop together leave it stopped.
        wr(1, 16'h000C, "R3"); rd(0, "R3");
        check(bus_rdata[1] === 1'b0, "R3 go+halt", bus_rdata, 32'h0);
        wr(1, 16'h0004, "R3"); idle(3); wr(1, 16'h0008, "R3"); idle(3);
        wr(4, 16'h0, "R3"); rd(4, "R3"); rd(5, "R3");
        // R1: writes to offsets 6 and 7 are ignored.
        wr(6, 16'hFFFF, "R1"); wr(7, 16'hFFFF, "R1");
        for (int o = 0; o < 8; o++) rd(o, "R1");

        // Random traffic with small periods.
        for (int n = 0; n < 4000; n++) begin
            int o;
            logic [15:0] d;
            o = int'($urandom_range(0, 7));
            case (o)
                2: d = 16'($urandom_range(0, 6));
                3: d = ($urandom_range(0, 9) == 0) ? 16'd1 : 16'd0;
                1: d = 16'($urandom_range(0, 15));
                default: d = 16'($urandom);
            endcase
            if ($urandom_range(0, 2) == 0) cyc(1'b1, 1'b0, o, d, tag_of(o));
            else cyc(1'b0, ($urandom_range(0, 5) != 0), o, 16'd0, tag_of(o));
        end

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule